// File: doc/BRIEF.md
# Address Register Arithmetic Unit

This unit executes the address-register operations of a 32-bit processor that keeps its address registers and its data registers in two separate files. Each operation is presented with a 4-bit secondary opcode, two source indices, a destination index and a 2-bit scale field. The unit puts the two source indices on its read-index outputs. The surrounding harness returns the matching address-file and data-file words. The unit then computes a single result and, one clock later, issues exactly one write into either the address file or the data file.

The operations are address add and subtract, an add of a data register scaled by 1, 2, 4 or 8, and a conversion of a signed bit index into a word-aligned byte address. They also cover unsigned magnitude compares, equality compares and zero tests on address registers, which leave a 0/1 word in a data register, and three moves that copy a word within or between the files. The register files themselves stay outside the unit.

Top module: `addr_alu_unit`

## Requirements
- R1: Opcode 0 writes A[dst] = A[src1] + A[src2]. Opcode 1 writes A[dst] = A[src1] - A[src2]. Both wrap modulo 2^32.
- R2: Opcode 2 writes A[dst] = A[src2] + (D[src1] << shamt), with shamt in the range 0 to 3. Bits shifted past bit 31 are lost.
- R3: Opcode 3 writes A[dst] = (A[src2] + (D[src1] arithmetically shifted right by 3)) with bits 1:0 of the sum cleared.
- R4: Opcode 4 writes D[dst] = 1 when A[src1] equals A[src2] and 0 otherwise. Opcode 5 writes the inverse. The result is a full 32-bit word.
- R5: Opcode 6 writes D[dst] = 1 when A[src1] >= A[src2]. Opcode 7 writes D[dst] = 1 when A[src1] < A[src2]. Both compares are unsigned.
- R6: Opcode 8 writes D[dst] = 1 when A[src1] is zero. Opcode 9 writes D[dst] = 1 when A[src1] is nonzero.
- R7: Opcode 10 writes A[dst] = D[src2]. Opcode 11 writes A[dst] = A[src2]. Opcode 12 writes D[dst] = A[src2].
- R8: For an accepted opcode 0 to 12, exactly one of wr_a_en and wr_d_en is high with out_valid. Opcodes 13 to 15 raise out_valid with both enables low.
- R9: The result, the destination index and the enables appear exactly one clock after the edge that samples in_valid high. A cycle without in_valid gives out_valid low and both enables low on the next cycle.
- R10: While rst is high, and on the cycle after it is released, out_valid, wr_a_en and wr_d_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Secondary opcode |
| src1_idx | input | 4 | First source register index |
| src2_idx | input | 4 | Second source register index |
| dst_idx | input | 4 | Destination register index |
| shamt | input | 2 | Scale shift for opcode 2 |
| rd_idx1 | output | 4 | Read index for the first operands of both files |
| rd_idx2 | output | 4 | Read index for the second operands of both files |
| a_rd1 | input | 32 | A[rd_idx1] |
| a_rd2 | input | 32 | A[rd_idx2] |
| d_rd1 | input | 32 | D[rd_idx1] |
| d_rd2 | input | 32 | D[rd_idx2] |
| out_valid | output | 1 | Registered result present |
| wr_a_en | output | 1 | Write wr_data into the address file |
| wr_d_en | output | 1 | Write wr_data into the data file |
| wr_idx | output | 4 | Destination index of the write |
| wr_data | output | 32 | Write data |

## Verification
The bench aims at carry and borrow wrap in the address add and subtract, where a design that kept extra width or sign-extended would write a wrong word. It feeds negative bit indices to opcode 3: a logical shift in place of an arithmetic one gives a huge positive offset, and a missing mask leaves bits 1:0 set. Compares use operands with bit 31 set, so a signed compare flips the answer. Opcodes 13 to 15 must leave both enables low, since a stray write would corrupt a register.

// File: rtl/addr_alu_pkg.sv
package addr_alu_pkg;
    parameter int XLEN   = 32;
    parameter int RIDX_W = 4;
    parameter int OP_W   = 4;
    parameter int SH_W   = 2;
    localparam int BIT_TO_BYTE = 3;
    localparam int ALIGN_BITS  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_AADD   = 4'd0,
        OP_ASUB   = 4'd1,
        OP_SCADD  = 4'd2,
        OP_BITADD = 4'd3,
        OP_CMPEQ  = 4'd4,
        OP_CMPNE  = 4'd5,
        OP_CMPGEU = 4'd6,
        OP_CMPLTU = 4'd7,
        OP_ZEQ    = 4'd8,
        OP_ZNE    = 4'd9,
        OP_MOVDA  = 4'd10,
        OP_MOVAA  = 4'd11,
        OP_MOVAD  = 4'd12
    } aop_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ADDR = 2'd1,
        TGT_DATA = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [RIDX_W-1:0] idx;
        logic [XLEN-1:0]   data;
    } wb_s;

    function automatic tgt_e op_target(input logic [OP_W-1:0] code);
        case (code)
            OP_AADD, OP_ASUB, OP_SCADD, OP_BITADD,
            OP_MOVDA, OP_MOVAA:                          return TGT_ADDR;
            OP_CMPEQ, OP_CMPNE, OP_CMPGEU, OP_CMPLTU,
            OP_ZEQ, OP_ZNE, OP_MOVAD:                    return TGT_DATA;
            default:                                     return TGT_NONE;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] as_flag(input logic b);
        return {{(XLEN-1){1'b0}}, b};
    endfunction
endpackage

// File: rtl/addr_alu_exec.sv
module addr_alu_exec
    import addr_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [SH_W-1:0] shamt,
    input  logic [XLEN-1:0] a1,
    input  logic [XLEN-1:0] a2,
    input  logic [XLEN-1:0] d1,
    input  logic [XLEN-1:0] d2,
    output logic [XLEN-1:0] result
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~((XLEN'(1) << ALIGN_BITS) - XLEN'(1));

    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] byte_off;
    logic [XLEN-1:0] bit_sum;
    logic            is_cmp;

    always_comb begin
        scaled   = d1 << shamt;
        byte_off = XLEN'($signed(d1) >>> BIT_TO_BYTE);
        bit_sum  = a2 + byte_off;
    end

    always_comb begin
        is_cmp = 1'b0;
        case (op)
            OP_AADD:   result = a1 + a2;
            OP_ASUB:   result = a1 - a2;
            OP_SCADD:  result = a2 + scaled;
            OP_BITADD: result = bit_sum & ALIGN_MASK;
            OP_CMPEQ:  begin result = as_flag(a1 == a2); is_cmp = 1'b1; end
            OP_CMPNE:  begin result = as_flag(a1 != a2); is_cmp = 1'b1; end
            OP_CMPGEU: begin result = as_flag(a1 >= a2); is_cmp = 1'b1; end
            OP_CMPLTU: begin result = as_flag(a1 <  a2); is_cmp = 1'b1; end
            OP_ZEQ:    begin result = as_flag(a1 == '0); is_cmp = 1'b1; end
            OP_ZNE:    begin result = as_flag(a1 != '0); is_cmp = 1'b1; end
            OP_MOVDA:  result = d2;
            OP_MOVAA:  result = a2;
            OP_MOVAD:  result = a2;
            default:   result = '0;
        endcase
    end

    always_comb begin
        if (is_cmp) begin
            AST_FLAG_ONE_BIT: assert (result[XLEN-1:1] == '0); // R4
        end
    end
endmodule

// File: rtl/addr_alu_wb.sv
module addr_alu_wb
    import addr_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  wb_s               nxt,
    output logic              out_valid,
    output logic              wr_a_en,
    output logic              wr_d_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data
);
    wb_s  held;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            held  <= '{tgt: TGT_NONE, idx: '0, data: '0};
        end else begin
            vld_q <= in_valid;
            if (in_valid) held <= nxt;
            else          held.tgt <= TGT_NONE;
        end
    end

    always_comb begin
        out_valid = vld_q;
        wr_a_en   = vld_q && (held.tgt == TGT_ADDR);
        wr_d_en   = vld_q && (held.tgt == TGT_DATA);
        wr_idx    = held.idx;
        wr_data   = held.data;
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        !(wr_a_en && wr_d_en)); // R8
    AST_EN_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        (wr_a_en || wr_d_en) |-> out_valid); // R8
endmodule

// File: rtl/addr_alu_unit.sv
module addr_alu_unit
    import addr_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [RIDX_W-1:0] src1_idx,
    input  logic [RIDX_W-1:0] src2_idx,
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic [SH_W-1:0]   shamt,
    output logic [RIDX_W-1:0] rd_idx1,
    output logic [RIDX_W-1:0] rd_idx2,
    input  logic [XLEN-1:0]   a_rd1,
    input  logic [XLEN-1:0]   a_rd2,
    input  logic [XLEN-1:0]   d_rd1,
    input  logic [XLEN-1:0]   d_rd2,
    output logic              out_valid,
    output logic              wr_a_en,
    output logic              wr_d_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data
);
    logic [XLEN-1:0] result;
    wb_s             nxt;

    assign rd_idx1 = src1_idx;
    assign rd_idx2 = src2_idx;

    addr_alu_exec u_exec (
        .op     (op),
        .shamt  (shamt),
        .a1     (a_rd1),
        .a2     (a_rd2),
        .d1     (d_rd1),
        .d2     (d_rd2),
        .result (result)
    );

    always_comb begin
        nxt.tgt  = op_target(op);
        nxt.idx  = dst_idx;
        nxt.data = result;
    end

    addr_alu_wb u_wb (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .nxt       (nxt),
        .out_valid (out_valid),
        .wr_a_en   (wr_a_en),
        .wr_d_en   (wr_d_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    AST_BAD_OP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > OP_W'(12)) |=> (out_valid && !wr_a_en && !wr_d_en)); // R8
    AST_GOOD_OP_WRITES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op <= OP_W'(12)) |=> (wr_a_en || wr_d_en)); // R8
    AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && wr_idx == $past(dst_idx))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_a_en && !wr_d_en)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !wr_a_en && !wr_d_en)); // R10
endmodule

// File: tb/addr_alu_unit_test.sv
module addr_alu_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0, src1_idx = '0, src2_idx = '0, dst_idx = '0;
    logic [1:0]  shamt = '0;
    logic [3:0]  rd_idx1, rd_idx2, wr_idx;
    logic [31:0] a_rd1, a_rd2, d_rd1, d_rd2, wr_data;
    logic        out_valid, wr_a_en, wr_d_en;

    logic [31:0] areg [16];
    logic [31:0] dreg [16];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign a_rd1 = areg[rd_idx1];
    assign a_rd2 = areg[rd_idx2];
    assign d_rd1 = dreg[rd_idx1];
    assign d_rd2 = dreg[rd_idx2];

    addr_alu_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src1_idx(src1_idx), .src2_idx(src2_idx), .dst_idx(dst_idx), .shamt(shamt),
        .rd_idx1(rd_idx1), .rd_idx2(rd_idx2),
        .a_rd1(a_rd1), .a_rd2(a_rd2), .d_rd1(d_rd1), .d_rd2(d_rd2),
        .out_valid(out_valid), .wr_a_en(wr_a_en), .wr_d_en(wr_d_en),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // target: 0 none, 1 address file, 2 data file
    function automatic logic [33:0] model(input logic [3:0] c, input logic [31:0] a1, a2, d1, d2,
                                          input logic [1:0] n);
        logic [31:0] t;
        case (c)
            4'd0:  return {2'd1, a1 + a2};
            4'd1:  return {2'd1, a1 - a2};
            4'd2:  return {2'd1, a2 + d1 * (32'd1 << n)};
            4'd3:  begin
                       t = a2 + 32'($signed(d1) / 8 - (($signed(d1) < 0 && d1[2:0] != 0) ? 1 : 0));
                       return {2'd1, t & 32'hFFFF_FFFC};
                   end
            4'd4:  return {2'd2, 31'd0, a1 == a2};
            4'd5:  return {2'd2, 31'd0, a1 != a2};
            4'd6:  return {2'd2, 31'd0, {1'b0, a1} >= {1'b0, a2}};
            4'd7:  return {2'd2, 31'd0, {1'b0, a1} <  {1'b0, a2}};
            4'd8:  return {2'd2, 31'd0, a1 == 0};
            4'd9:  return {2'd2, 31'd0, a1 != 0};
            4'd10: return {2'd1, d2};
            4'd11: return {2'd1, a2};
            4'd12: return {2'd2, a2};
            default: return {2'd0, 32'd0};
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd0, 4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4, 4'd5: return "R4";
            4'd6, 4'd7: return "R5";
            4'd8, 4'd9: return "R6";
            4'd10, 4'd11, 4'd12: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] c, input logic [3:0] s1, s2, d, input logic [1:0] n);
        logic [33:0] e;
        string tg;
        e = model(c, areg[s1], areg[s2], dreg[s1], dreg[s2], n);
        tg = tag_of(c);
        op = c; src1_idx = s1; src2_idx = s2; dst_idx = d; shamt = n; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, {tg, " R9 out_valid"}, 64'(out_valid), 64'd1);
        check(wr_a_en === (e[33:32] == 2'd1) && wr_d_en === (e[33:32] == 2'd2),
              {tg, " R8 enables"}, {62'd0, wr_a_en, wr_d_en}, {62'd0, e[33:32] == 2'd1, e[33:32] == 2'd2});
        if (e[33:32] != 2'd0) begin
            check(wr_data === e[31:0], {tg, " data"}, 64'(wr_data), 64'(e[31:0]));
            check(wr_idx === d, {tg, " R9 wr_idx"}, 64'(wr_idx), 64'(d));
        end
        if (wr_a_en === 1'b1) areg[wr_idx] = wr_data;
        if (wr_d_en === 1'b1) dreg[wr_idx] = wr_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin
            areg[i] = $urandom;
            dreg[i] = $urandom;
        end
        in_valid = 1'b1;
        op = 4'd0;
        repeat (3) @(negedge clk);
        // R10: reset holds outputs low even with in_valid high
        check(out_valid === 1'b0 && wr_a_en === 1'b0 && wr_d_en === 1'b0, "R10 reset",
              {61'd0, out_valid, wr_a_en, wr_d_en}, 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R10 after release", 64'(out_valid), 64'd0);

        // directed corners
        areg[1] = 32'hFFFF_FFFF; areg[2] = 32'd2;
        run_op(4'd0, 4'd1, 4'd2, 4'd3, 2'd0);            // R1 wrap to 1
        areg[4] = 32'd0; areg[5] = 32'd1;
        run_op(4'd1, 4'd4, 4'd5, 4'd6, 2'd0);            // R1 borrow to FFFFFFFF
        dreg[7] = 32'h4000_0003; areg[8] = 32'h100;
        run_op(4'd2, 4'd7, 4'd8, 4'd9, 2'd3);            // R2 shift past bit 31
        run_op(4'd2, 4'd7, 4'd8, 4'd9, 2'd0);            // R2 unscaled
        dreg[10] = 32'hFFFF_FFF1; areg[11] = 32'h1000_0007;
        run_op(4'd3, 4'd10, 4'd11, 4'd12, 2'd0);         // R3 negative bit index
        dreg[10] = 32'h0000_0105;
        run_op(4'd3, 4'd10, 4'd11, 4'd12, 2'd1);         // R3 positive, mask
        areg[1] = 32'h8000_0000; areg[2] = 32'h0000_0001;
        run_op(4'd6, 4'd1, 4'd2, 4'd3, 2'd0);            // R5 unsigned GE true
        run_op(4'd7, 4'd1, 4'd2, 4'd3, 2'd0);            // R5 unsigned LT false
        run_op(4'd7, 4'd2, 4'd2, 4'd3, 2'd0);            // R5 equal -> LT 0
        run_op(4'd6, 4'd2, 4'd2, 4'd3, 2'd0);            // R5 equal -> GE 1
        run_op(4'd4, 4'd5, 4'd5, 4'd6, 2'd0);            // R4 equal
        run_op(4'd5, 4'd1, 4'd2, 4'd6, 2'd0);            // R4 not equal
        areg[4] = 32'd0;
        run_op(4'd8, 4'd4, 4'd0, 4'd6, 2'd0);            // R6 zero
        run_op(4'd9, 4'd4, 4'd0, 4'd6, 2'd0);            // R6 nonzero test on zero
        run_op(4'd10, 4'd0, 4'd7, 4'd13, 2'd0);          // R7 D->A
        run_op(4'd11, 4'd0, 4'd1, 4'd14, 2'd0);          // R7 A->A
        run_op(4'd12, 4'd0, 4'd1, 4'd15, 2'd0);          // R7 A->D
        for (int c = 13; c < 16; c++) run_op(4'(c), 4'd1, 4'd2, 4'd3, 2'd2); // R8 unused codes
        // R9: idle cycle
        @(negedge clk);
        check(out_valid === 1'b0 && wr_a_en === 1'b0 && wr_d_en === 1'b0, "R9 idle",
              {61'd0, out_valid, wr_a_en, wr_d_en}, 64'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            run_op(4'($urandom_range(0, 15)), 4'($urandom), 4'($urandom), 4'($urandom), 2'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule